// File: doc/BRIEF.md
# Load Result Formatter

This block sits between a load/store unit's data return path and the register file write port. It takes the raw bytes that memory returned for a load and turns them into the 64-bit value that is written to the destination register. It applies zero extension, algebraic sign extension or byte reversal according to the access size. For a quadword load, it produces both halves of an even/odd register pair, ordered and byte-swapped according to an endianness mode input.

Bits are numbered big-endian in the requirements: bit 0 is the most significant bit of a 64-bit value, which is `[63]` in the RTL vectors. Raw data arrives right-justified in storage order. For an N-byte access, storage byte k (k = 0 at the lowest address) sits at `in_dw0[8*(N-1-k)+7 : 8*(N-1-k)]`. For a quadword, `in_dw0` holds the doubleword at the effective address (EA) and `in_dw1` holds the doubleword at EA+8.

Requests enter on a valid/ready handshake, and results leave on one. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its result appears registered on `out_even`/`out_odd` with `out_valid` high from the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken.

Top module: `ldx_load_format`

## Requirements
- R1: With `in_size`=0 (1 byte), `out_even` equals the low byte of `in_dw0` with bits 0:55 cleared; `in_signed` and `in_reverse` have no effect.
- R2: With `in_size`=1 (2 bytes), `in_signed`=0 and `in_reverse`=0, `out_even` holds `in_dw0[15:0]` in bits 48:63 and zeros in bits 0:47.
- R3: With `in_size`=2 (4 bytes), `in_signed`=0 and `in_reverse`=0, `out_even` holds `in_dw0[31:0]` in bits 32:63 and zeros in bits 0:31.
- R4: With `in_signed`=1, `in_reverse`=0 and a 2- or 4-byte size, the bits above the loaded item are all copies of the item's bit 0 (`in_dw0[15]` or `in_dw0[31]`).
- R5: With `in_reverse`=1 and a 2-, 4- or 8-byte size, storage byte k of the item lands in result byte k counted from the least significant end (storage byte 0 in bits 56:63), and the bits above the item are zero.
- R6: With `in_size`=3 (8 bytes) and `in_reverse`=0, `out_even` equals `in_dw0`; `in_signed` has no effect.
- R7: When `in_reverse` and `in_signed` are both 1, byte reversal applies and the result is zero-extended.
- R8: With `in_quad`=1 and `in_little`=0, `out_even` = `in_dw0` and `out_odd` = `in_dw1`; size, sign and reverse inputs are ignored.
- R9: With `in_quad`=1 and `in_little`=1, `out_even` is `in_dw1` byte-reversed and `out_odd` is `in_dw0` byte-reversed.
- R10: With `in_quad`=0, `out_odd` is zero and `in_dw1` has no effect.
- R11: `in_ready` = !`out_valid` || `out_ready`; an accepted request gives `out_valid` high next cycle; while `out_valid` && !`out_ready`, `out_valid`, `out_even` and `out_odd` stay unchanged.
- R12: During and right after reset (`rst_n` low), `out_valid` is low and both results are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_size | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| in_signed | input | 1 | Algebraic (sign-extending) load |
| in_reverse | input | 1 | Byte-reversed load |
| in_quad | input | 1 | Register-pair (quadword) load |
| in_little | input | 1 | Little-endian mode for register pairs |
| in_dw0 | input | 64 | Raw data; doubleword at EA for quadword |
| in_dw1 | input | 64 | Doubleword at EA+8 (quadword only) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_even | output | 64 | Register result, or even register of a pair |
| out_odd | output | 64 | Odd register of a pair, zero otherwise |

## Verification
On every cycle, the assertions check the handshake rules: ready while empty, a valid result after each accepted request, and a held result under back-pressure. They also check reset clearing and several shape properties of the output. These are zero tops for byte, word and reversed loads, sign-copy tops for algebraic halfwords, and a zero odd half for single loads. Exact byte placement cannot be expressed as a shape property, so only the bench shows it. This covers the reversed byte order, the doubleword pair ordering in both endian modes, and the precedence of reversal over sign extension. The bench sweeps every control combination across a set of data patterns and compares against arithmetically computed values.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  localparam int unsigned XLEN    = 64;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned XBYTES  = XLEN / BYTE_W;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } ldx_size_e;

  typedef struct packed {
    ldx_size_e size;
    logic      sgn;
    logic      rev;
    logic      quad;
    logic      little;
  } ldx_ctrl_t;
endpackage

// File: rtl/ldx_swap.sv
module ldx_swap #(
  parameter int unsigned NB     = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned W     = NB * BYTE_W
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign dout[i*BYTE_W +: BYTE_W] = din[(NB-1-i)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/ldx_extend.sv
module ldx_extend
  import ldx_pkg::*;
#(
  parameter int unsigned DW = XLEN
) (
  input  ldx_size_e       size,
  input  logic            sgn,
  input  logic            rev,
  input  logic [DW-1:0]   raw,
  output logic [DW-1:0]   result
);
  localparam int unsigned NB  = DW / BYTE_W;
  localparam int unsigned HW  = 2 * BYTE_W;
  localparam int unsigned WW  = 4 * BYTE_W;

  logic [DW-1:0] fld;
  logic [DW-1:0] swapped;

  // keep only the accessed bytes before the full-width reversal
  always_comb begin
    unique case (size)
      SZ_BYTE: fld = {{(DW-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};
      SZ_HALF: fld = {{(DW-HW){1'b0}}, raw[HW-1:0]};
      SZ_WORD: fld = {{(DW-WW){1'b0}}, raw[WW-1:0]};
      default: fld = raw;
    endcase
  end

  ldx_swap #(.NB(NB), .BYTE_W(BYTE_W)) u_swap (
    .din  (fld),
    .dout (swapped)
  );

  always_comb begin
    unique case (size)
      SZ_BYTE: result = fld;
      SZ_HALF: begin
        if (rev)      result = swapped >> (DW - HW);
        else if (sgn) result = {{(DW-HW){fld[HW-1]}}, fld[HW-1:0]};
        else          result = fld;
      end
      SZ_WORD: begin
        if (rev)      result = swapped >> (DW - WW);
        else if (sgn) result = {{(DW-WW){fld[WW-1]}}, fld[WW-1:0]};
        else          result = fld;
      end
      default: result = rev ? swapped : fld;
    endcase
  end
endmodule

// File: rtl/ldx_pair.sv
module ldx_pair
  import ldx_pkg::*;
#(
  parameter int unsigned DW = XLEN
) (
  input  logic          little,
  input  logic [DW-1:0] dw_lo_addr,
  input  logic [DW-1:0] dw_hi_addr,
  output logic [DW-1:0] even_q,
  output logic [DW-1:0] odd_q
);
  localparam int unsigned NB = DW / BYTE_W;

  logic [DW-1:0] lo_sw;
  logic [DW-1:0] hi_sw;

  ldx_swap #(.NB(NB), .BYTE_W(BYTE_W)) u_sw_lo (.din(dw_lo_addr), .dout(lo_sw));
  ldx_swap #(.NB(NB), .BYTE_W(BYTE_W)) u_sw_hi (.din(dw_hi_addr), .dout(hi_sw));

  always_comb begin
    if (little) begin
      even_q = hi_sw;
      odd_q  = lo_sw;
    end else begin
      even_q = dw_lo_addr;
      odd_q  = dw_hi_addr;
    end
  end
endmodule

// File: rtl/ldx_load_format.sv
module ldx_load_format
  import ldx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  in_size,
  input  logic        in_signed,
  input  logic        in_reverse,
  input  logic        in_quad,
  input  logic        in_little,
  input  logic [63:0] in_dw0,
  input  logic [63:0] in_dw1,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_even,
  output logic [63:0] out_odd
);
  localparam int unsigned DW = XLEN;

  ldx_ctrl_t     ctl;
  logic [DW-1:0] single_res;
  logic [DW-1:0] pair_even;
  logic [DW-1:0] pair_odd;
  logic [DW-1:0] nxt_even;
  logic [DW-1:0] nxt_odd;
  logic          take;

  assign ctl = '{size: ldx_size_e'(in_size), sgn: in_signed, rev: in_reverse,
                 quad: in_quad, little: in_little};

  ldx_extend #(.DW(DW)) u_ext (
    .size   (ctl.size),
    .sgn    (ctl.sgn),
    .rev    (ctl.rev),
    .raw    (in_dw0),
    .result (single_res)
  );

  ldx_pair #(.DW(DW)) u_pair (
    .little     (ctl.little),
    .dw_lo_addr (in_dw0),
    .dw_hi_addr (in_dw1),
    .even_q     (pair_even),
    .odd_q      (pair_odd)
  );

  always_comb begin
    if (ctl.quad) begin
      nxt_even = pair_even;
      nxt_odd  = pair_odd;
    end else begin
      nxt_even = single_res;
      nxt_odd  = '0;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_even  <= '0;
      out_odd   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_even  <= nxt_even;
      out_odd   <= nxt_odd;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ldx_load_format_chk.sv
module ldx_load_format_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_size,
  input logic        in_signed,
  input logic        in_reverse,
  input logic        in_quad,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_even,
  input logic [63:0] out_odd
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R11
  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R11
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_even) && $stable(out_odd)); // R11
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid && out_even == 64'd0 && out_odd == 64'd0); // R12
  AST_BYTE_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_quad && in_size == 2'd0 |=> out_even[63:8] == 56'd0); // R1
  AST_WORD_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_quad && in_size == 2'd2 && !in_signed |=> out_even[63:32] == 32'd0); // R3
  AST_HALF_SIGN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_quad && in_size == 2'd1 && in_signed && !in_reverse
      |=> out_even[63:16] == {48{out_even[15]}}); // R4
  AST_REV_BEATS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_quad && in_size == 2'd2 && in_signed && in_reverse
      |=> out_even[63:32] == 32'd0); // R7
  AST_ODD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_quad |=> out_odd == 64'd0); // R10
endmodule

bind ldx_load_format ldx_load_format_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_size    (in_size),
  .in_signed  (in_signed),
  .in_reverse (in_reverse),
  .in_quad    (in_quad),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_even   (out_even),
  .out_odd    (out_odd)
);

// File: tb/ldx_load_format_tb_top.sv
module ldx_load_format_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_size = 2'd0;
  logic        in_signed = 1'b0;
  logic        in_reverse = 1'b0;
  logic        in_quad = 1'b0;
  logic        in_little = 1'b0;
  logic [63:0] in_dw0 = '0;
  logic [63:0] in_dw1 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_even;
  logic [63:0] out_odd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ldx_load_format dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_size(in_size), .in_signed(in_signed), .in_reverse(in_reverse),
    .in_quad(in_quad), .in_little(in_little), .in_dw0(in_dw0), .in_dw1(in_dw1),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_even(out_even), .out_odd(out_odd)
  );

  function automatic logic [63:0] rev_bytes(input logic [63:0] v, input int n);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) r[8*k +: 8] = v[8*(n-1-k) +: 8];
    return r;
  endfunction

  function automatic string req_of(input int sz, input bit sg, input bit rv, input bit qd, input bit le);
    if (qd) return le ? "R9" : "R8";
    if (sz == 0) return "R1";
    if (rv && sg) return "R7";
    if (rv) return "R5";
    if (sz == 3) return "R6";
    if (sg) return "R4";
    return (sz == 1) ? "R2" : "R3";
  endfunction

  task automatic check64(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input int sz, input bit sg, input bit rv, input bit qd, input bit le,
                         input logic [63:0] d0, input logic [63:0] d1);
    logic [63:0] ee, eo, mask;
    int n;
    string rq;
    n = 1 << sz;
    mask = (n == 8) ? {64{1'b1}} : ((64'd1 << (8*n)) - 64'd1);
    if (qd) begin
      ee = le ? rev_bytes(d1, 8) : d0;
      eo = le ? rev_bytes(d0, 8) : d1;
    end else begin
      ee = d0 & mask;
      if (rv) ee = rev_bytes(ee, n);
      else if (sg && (sz == 1 || sz == 2) && ee[8*n-1]) ee = ee | ~mask;
      eo = '0;
    end
    rq = req_of(sz, sg, rv, qd, le);
    in_size = sz[1:0]; in_signed = sg; in_reverse = rv; in_quad = qd; in_little = le;
    in_dw0 = d0; in_dw1 = d1; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check64("R11", "out_valid", {63'd0, out_valid}, 64'd1);
    check64(rq, "out_even", out_even, ee);
    check64(qd ? rq : "R10", "out_odd", out_odd, eo);
  endtask

  logic [63:0] pats [8];

  initial begin
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hFEDC_BA98_7654_3210;
    pats[2] = 64'h8000_8000_8000_8080;
    pats[3] = 64'h7F7F_7F7F_7F7F_7F7F;
    pats[4] = 64'h0000_0000_0000_0000;
    pats[5] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[6] = 64'h1234_5678_8000_7FFF;
    pats[7] = 64'hA5C3_0F96_E1B4_8001;

    repeat (3) @(negedge clk);
    // R12: reset state, still inside reset
    check64("R12", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    check64("R12", "out_even in reset", out_even, 64'd0);
    check64("R12", "out_odd in reset", out_odd, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R12", "out_valid after reset", {63'd0, out_valid}, 64'd0);
    check64("R11", "in_ready when empty", {63'd0, in_ready}, 64'd1);

    // exhaustive control sweep across data patterns
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 64; c++)
        run_one(c & 3, c[2], c[3], c[4], c[5], pats[p], {pats[7-p][31:0], pats[7-p][63:32]});

    // R11 back-pressure: hold result, refuse new request
    @(negedge clk);
    out_ready = 1'b0;
    in_size = 2'd3; in_signed = 0; in_reverse = 0; in_quad = 0; in_little = 0;
    in_dw0 = 64'h1111_2222_3333_4444; in_dw1 = '0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_dw0 = 64'h5555_6666_7777_8888;
    check64("R11", "in_ready under back-pressure", {63'd0, in_ready}, 64'd0);
    repeat (3) @(negedge clk);
    check64("R11", "held valid", {63'd0, out_valid}, 64'd1);
    check64("R11", "held result", out_even, 64'h1111_2222_3333_4444);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check64("R11", "next result after drain", out_even, 64'h5555_6666_7777_8888);
    @(posedge clk);
    @(negedge clk);
    check64("R11", "empty after drain", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule